// File: doc/BRIEF.md
# Page CAM Shared-Access Locator

This block sits in front of a local table that records shared-memory access footprints. Each incoming access carries an address, the id of the core that issued it and a read/write flag. The block looks up the address's 4 KB page in a small fully associative CAM. On a hit it returns the index of the table entry that covers the access's monitoring unit. On a miss it passes the access out on a forward stream so that a remote node can handle it. The result appears one cycle after the request is accepted.

The table has `TABLE_DEPTH` entries, split evenly among the `CAM_SLOTS` CAM slots, so slot `s` owns the consecutive entries starting at `s * (TABLE_DEPTH / CAM_SLOTS)`. A runtime granularity input sets the size of a monitoring unit, from 128 bytes (32 words) up to a whole 4 KB page. A unit offset too large for the partition is clamped to the partition's last entry.

Pages enter the CAM through a separate allocate/release control port. An allocated page stays resident until it is released explicitly.

Access requests arrive on a valid/ready stream. Results leave on one of two valid/ready streams: hit results or forwarded misses. There is a single output register. While a result waits because its consumer holds ready low, the register and its fields stay frozen and `req_ready` is low, so back-pressure reaches the requester directly. The allocate/release port and its outputs are plain control signals with no handshake.

Top module: `page_cam_locator`

## Requirements
- R1: After reset, every CAM slot is free, `res_valid`, `fwd_valid`, `alloc_done` and `alloc_full` are low, and `req_ready` is high.
- R2: An accepted request whose page is resident produces `res_valid` on the next cycle. `res_index` equals slot*16 + min(offset >> (7+g), 15), where offset is address bits [11:0] and g is the effective granularity. This uses the default 8 slots and 128 table entries.
- R3: `gran_sel` value g selects a unit of 128 << g bytes for g = 0..5. Values 6 and 7 act as 5, a whole 4 KB page.
- R4: A unit offset that is greater than or equal to the partition size (16) is clamped to 15, the last entry of the page's partition.
- R5: An accepted request whose page is not resident produces `fwd_valid` on the next cycle. `fwd_addr`, `fwd_core` and `fwd_write` carry the request unchanged, and `res_valid` stays low.
- R6: While a valid result is not accepted by its consumer, the result stays valid with unchanged fields and `req_ready` is low. One cycle after the consumer accepts it, the valid output drops.
- R7: An allocation of a page that is not resident takes the lowest-numbered free slot. On the next cycle it pulses `alloc_done`, with that slot on `alloc_slot`.
- R8: An allocation when no slot is free pulses `alloc_full`, does not pulse `alloc_done`, and leaves the CAM unchanged, so a later lookup of that page is forwarded.
- R9: A release frees the slot holding the page. Later lookups of that page are forwarded, and the freed slot is again a candidate for the lowest-free allocation.
- R10: Allocating a page that is already resident creates no second entry. It pulses `alloc_done` with the existing slot.
- R11: Lookups, allocations and releases issued in the same cycle all see the CAM as it stood before that cycle. A lookup of a page allocated in the same cycle is forwarded. A slot released in the same cycle cannot serve an allocation in that cycle.
- R12: `alloc_done` and `alloc_full` pulse only in the cycle after `alloc_en` was high, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gran_sel | input | 3 | Monitoring unit size code (128 << g bytes) |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be accepted |
| req_addr | input | 32 | Access byte address |
| req_core | input | 4 | Issuing core id |
| req_write | input | 1 | Access is a write |
| res_valid | output | 1 | Hit result valid |
| res_ready | input | 1 | Hit result consumer ready |
| res_index | output | 7 | Table index for the access |
| res_core | output | 4 | Core id of the hit access |
| res_write | output | 1 | Write flag of the hit access |
| fwd_valid | output | 1 | Forwarded miss valid |
| fwd_ready | input | 1 | Forward consumer ready |
| fwd_addr | output | 32 | Address of the missed access |
| fwd_core | output | 4 | Core id of the missed access |
| fwd_write | output | 1 | Write flag of the missed access |
| alloc_en | input | 1 | Allocate a page |
| alloc_page | input | 20 | Page number to allocate |
| rel_en | input | 1 | Release a page |
| rel_page | input | 20 | Page number to release |
| alloc_done | output | 1 | Allocation completed (pulse) |
| alloc_slot | output | 3 | Slot holding the allocated page |
| alloc_full | output | 1 | Allocation refused, CAM full (pulse) |

## Verification
A lookup can land in the same cycle as an allocation or release that changes the CAM contents. A release can also coincide with an allocation that needs the slot being freed. The bench drives a lookup and an allocation of the same new page on one clock edge and expects the lookup to be forwarded while the allocation succeeds. A repeated lookup must then hit. With the CAM full, it pairs a release with an allocation and expects `alloc_full`. A further allocation must then reuse the released slot.

// File: rtl/pcam_pkg.sv
package pcam_pkg;

  // Kind of result held in the output register.
  typedef enum logic {
    OUT_HIT = 1'b0,
    OUT_FWD = 1'b1
  } pcam_out_kind_e;

  // Smallest monitoring unit is 2**7 bytes (32 words of 4 bytes).
  localparam int PCAM_MIN_UNIT_SHIFT = 7;

endpackage

// File: rtl/pcam_match.sv
module pcam_match #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] al_tag,
  input  logic [TAG_W-1:0] rl_tag,
  input  logic [SLOTS-1:0] set_vec,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [SLOTS-1:0] clr_vec,
  output logic [SLOTS-1:0] valid_vec,
  output logic [SLOTS-1:0] lk_hit_vec,
  output logic [SLOTS-1:0] al_hit_vec,
  output logic [SLOTS-1:0] rl_hit_vec
);

  logic [TAG_W-1:0] tags [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[s] <= 1'b0;
        tags[s]      <= '0;
      end else if (set_vec[s]) begin
        valid_vec[s] <= 1'b1;
        tags[s]      <= set_tag;
      end else if (clr_vec[s]) begin
        valid_vec[s] <= 1'b0;
      end
    end

    assign lk_hit_vec[s] = valid_vec[s] && (tags[s] == lk_tag);
    assign al_hit_vec[s] = valid_vec[s] && (tags[s] == al_tag);
    assign rl_hit_vec[s] = valid_vec[s] && (tags[s] == rl_tag);
  end

endmodule

// File: rtl/pcam_alloc.sv
module pcam_alloc #(
  parameter int SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]  valid_vec,
  input  logic [SLOTS-1:0]  al_hit_vec,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  output logic              dup_any,
  output logic [SLOT_W-1:0] dup_slot
);

  // Lowest free slot: scan from the top so the lowest index wins.
  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!valid_vec[s]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(s);
      end
    end
  end

  // Encode the slot already holding the requested page, if any.
  always_comb begin
    dup_any  = 1'b0;
    dup_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (al_hit_vec[s]) begin
        dup_any  = 1'b1;
        dup_slot = SLOT_W'(s);
      end
    end
  end

endmodule

// File: rtl/pcam_index.sv
module pcam_index #(
  parameter int SLOTS      = 8,
  parameter int DEPTH      = 128,
  parameter int PAGE_SHIFT = 12,
  parameter int GRAN_W     = 3,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int PART      = DEPTH / SLOTS,
  localparam int PART_W    = $clog2(PART),
  localparam int IDX_W     = SLOT_W + PART_W
) (
  input  logic [SLOT_W-1:0]     slot,
  input  logic [PAGE_SHIFT-1:0] offset,
  input  logic [GRAN_W-1:0]     gran,
  output logic [IDX_W-1:0]      index
);

  localparam int GRAN_MAX = PAGE_SHIFT - pcam_pkg::PCAM_MIN_UNIT_SHIFT;
  localparam int SH_W     = $clog2(PAGE_SHIFT + 1);

  logic [GRAN_W-1:0]     eff_gran;
  logic [SH_W-1:0]       shamt;
  logic [PAGE_SHIFT-1:0] unit_off;
  logic [PART_W-1:0]     part_off;

  always_comb begin
    eff_gran = (gran > GRAN_W'(GRAN_MAX)) ? GRAN_W'(GRAN_MAX) : gran;
    shamt    = SH_W'(pcam_pkg::PCAM_MIN_UNIT_SHIFT) + SH_W'(eff_gran);
    unit_off = offset >> shamt;
    if (unit_off > PAGE_SHIFT'(PART - 1)) begin
      part_off = PART_W'(PART - 1);
    end else begin
      part_off = unit_off[PART_W-1:0];
    end
    index = {slot, part_off};
  end

endmodule

// File: rtl/page_cam_locator.sv
module page_cam_locator #(
  parameter int ADDR_W      = 32,
  parameter int CORE_W      = 4,
  parameter int PAGE_SHIFT  = 12,
  parameter int CAM_SLOTS   = 8,
  parameter int TABLE_DEPTH = 128,
  parameter int GRAN_W      = 3,
  localparam int TAG_W      = ADDR_W - PAGE_SHIFT,
  localparam int SLOT_W     = $clog2(CAM_SLOTS),
  localparam int IDX_W      = $clog2(TABLE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRAN_W-1:0] gran_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_write,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [IDX_W-1:0]  res_index,
  output logic [CORE_W-1:0] res_core,
  output logic              res_write,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [CORE_W-1:0] fwd_core,
  output logic              fwd_write,
  input  logic              alloc_en,
  input  logic [TAG_W-1:0]  alloc_page,
  input  logic              rel_en,
  input  logic [TAG_W-1:0]  rel_page,
  output logic              alloc_done,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              alloc_full
);

  import pcam_pkg::*;

  logic [CAM_SLOTS-1:0] valid_vec, lk_hit_vec, al_hit_vec, rl_hit_vec;
  logic [CAM_SLOTS-1:0] set_vec, clr_vec;
  logic                 free_any, dup_any, lk_hit;
  logic [SLOT_W-1:0]    free_slot, dup_slot, lk_slot;
  logic [IDX_W-1:0]     lk_index;

  // Output register
  logic                 out_valid;
  pcam_out_kind_e       out_kind;
  logic [IDX_W-1:0]     out_index;
  logic [ADDR_W-1:0]    out_addr;
  logic [CORE_W-1:0]    out_core;
  logic                 out_write;
  logic                 out_ready;
  logic                 req_fire;

  pcam_match #(.SLOTS(CAM_SLOTS), .TAG_W(TAG_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (req_addr[ADDR_W-1:PAGE_SHIFT]),
    .al_tag     (alloc_page),
    .rl_tag     (rel_page),
    .set_vec    (set_vec),
    .set_tag    (alloc_page),
    .clr_vec    (clr_vec),
    .valid_vec  (valid_vec),
    .lk_hit_vec (lk_hit_vec),
    .al_hit_vec (al_hit_vec),
    .rl_hit_vec (rl_hit_vec)
  );

  pcam_alloc #(.SLOTS(CAM_SLOTS)) u_alloc (
    .valid_vec  (valid_vec),
    .al_hit_vec (al_hit_vec),
    .free_any   (free_any),
    .free_slot  (free_slot),
    .dup_any    (dup_any),
    .dup_slot   (dup_slot)
  );

  pcam_index #(
    .SLOTS      (CAM_SLOTS),
    .DEPTH      (TABLE_DEPTH),
    .PAGE_SHIFT (PAGE_SHIFT),
    .GRAN_W     (GRAN_W)
  ) u_index (
    .slot   (lk_slot),
    .offset (req_addr[PAGE_SHIFT-1:0]),
    .gran   (gran_sel),
    .index  (lk_index)
  );

  // Encode the lookup hit slot.
  always_comb begin
    lk_hit  = 1'b0;
    lk_slot = '0;
    for (int s = CAM_SLOTS - 1; s >= 0; s--) begin
      if (lk_hit_vec[s]) begin
        lk_hit  = 1'b1;
        lk_slot = SLOT_W'(s);
      end
    end
  end

  // CAM update: set and clear act on disjoint slots (free vs resident).
  always_comb begin
    set_vec = '0;
    if (alloc_en && !dup_any && free_any) begin
      set_vec[free_slot] = 1'b1;
    end
    clr_vec = rel_en ? rl_hit_vec : '0;
  end

  // Request stream into the single output register.
  assign out_ready = (out_kind == OUT_FWD) ? fwd_ready : res_ready;
  assign req_ready = !out_valid || out_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= OUT_HIT;
      out_index <= '0;
      out_addr  <= '0;
      out_core  <= '0;
      out_write <= 1'b0;
    end else if (req_fire) begin
      out_valid <= 1'b1;
      out_kind  <= lk_hit ? OUT_HIT : OUT_FWD;
      out_index <= lk_index;
      out_addr  <= req_addr;
      out_core  <= req_core;
      out_write <= req_write;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign res_valid = out_valid && (out_kind == OUT_HIT);
  assign res_index = out_index;
  assign res_core  = out_core;
  assign res_write = out_write;
  assign fwd_valid = out_valid && (out_kind == OUT_FWD);
  assign fwd_addr  = out_addr;
  assign fwd_core  = out_core;
  assign fwd_write = out_write;

  // Allocation outcome, registered.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_done <= 1'b0;
      alloc_full <= 1'b0;
      alloc_slot <= '0;
    end else begin
      alloc_done <= alloc_en && (dup_any || free_any);
      alloc_full <= alloc_en && !dup_any && !free_any;
      if (alloc_en) begin
        alloc_slot <= dup_any ? dup_slot : free_slot;
      end
    end
  end

endmodule

// File: rtl/pcam_chk.sv
module pcam_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              lk_hit,
  input logic              res_valid,
  input logic              res_ready,
  input logic [IDX_W-1:0]  res_index,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              alloc_en,
  input logic              alloc_done,
  input logic              alloc_full
);

  // R2
  hit_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (res_valid && !fwd_valid));

  // R5
  miss_to_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lk_hit) |=> (fwd_valid && !res_valid));

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_index)));

  // R6
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)));

  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);

  // R12
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> $past(alloc_en));

  // R12
  full_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_full |-> ($past(alloc_en) && !alloc_done));

endmodule

bind page_cam_locator pcam_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .lk_hit     (lk_hit),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_index  (res_index),
  .fwd_valid  (fwd_valid),
  .fwd_ready  (fwd_ready),
  .fwd_addr   (fwd_addr),
  .alloc_en   (alloc_en),
  .alloc_done (alloc_done),
  .alloc_full (alloc_full)
);

// File: tb/page_cam_locator_tb.sv
module page_cam_locator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  gran_sel = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_core = '0;
  logic        req_write = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [6:0]  res_index;
  logic [3:0]  res_core;
  logic        res_write;
  logic        fwd_valid;
  logic        fwd_ready = 1'b1;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_core;
  logic        fwd_write;
  logic        alloc_en = 1'b0;
  logic [19:0] alloc_page = '0;
  logic        rel_en = 1'b0;
  logic [19:0] rel_page = '0;
  logic        alloc_done;
  logic [2:0]  alloc_slot;
  logic        alloc_full;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  page_cam_locator u_dut (
    .clk(clk), .rst_n(rst_n), .gran_sel(gran_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_core(req_core), .req_write(req_write),
    .res_valid(res_valid), .res_ready(res_ready), .res_index(res_index),
    .res_core(res_core), .res_write(res_write),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_core(fwd_core), .fwd_write(fwd_write),
    .alloc_en(alloc_en), .alloc_page(alloc_page),
    .rel_en(rel_en), .rel_page(rel_page),
    .alloc_done(alloc_done), .alloc_slot(alloc_slot), .alloc_full(alloc_full)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Allocation; results checked one cycle later.
  task automatic do_alloc(input logic [19:0] page, input bit exp_done,
                          input bit exp_full, input logic [2:0] exp_slot,
                          input string req);
    @(negedge clk);
    alloc_en = 1'b1; alloc_page = page;
    @(negedge clk);
    alloc_en = 1'b0;
    check(alloc_done == exp_done, {req, " done"}, 32'(alloc_done), 32'(exp_done));
    check(alloc_full == exp_full, {req, " full"}, 32'(alloc_full), 32'(exp_full));
    if (exp_done) check(alloc_slot == exp_slot, {req, " slot"}, 32'(alloc_slot), 32'(exp_slot));
  endtask

  task automatic do_release(input logic [19:0] page);
    @(negedge clk);
    rel_en = 1'b1; rel_page = page;
    @(negedge clk);
    rel_en = 1'b0;
  endtask

  // Lookup; exp_hit selects the expected stream.
  task automatic do_lookup(input logic [31:0] addr, input logic [2:0] g,
                           input bit exp_hit, input logic [6:0] exp_idx,
                           input string req);
    @(negedge clk);
    gran_sel = g; req_valid = 1'b1; req_addr = addr;
    req_core = addr[3:0]; req_write = addr[4];
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == exp_hit, {req, " res_valid"}, 32'(res_valid), 32'(exp_hit));
    check(fwd_valid == !exp_hit, {req, " fwd_valid"}, 32'(fwd_valid), 32'(!exp_hit));
    if (exp_hit) begin
      check(res_index == exp_idx, {req, " index"}, 32'(res_index), 32'(exp_idx));
      check(res_core == addr[3:0], {req, " core"}, 32'(res_core), 32'(addr[3:0]));
    end else begin
      check(fwd_addr == addr, {req, " fwd_addr"}, fwd_addr, addr);
      check(fwd_core == addr[3:0] && fwd_write == addr[4], {req, " fwd_tag"},
            {27'd0, fwd_write, fwd_core}, {27'd0, addr[4], addr[3:0]});
    end
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    check(!res_valid && !fwd_valid, "R1 outputs idle", {30'd0, res_valid, fwd_valid}, 0);
    check(!alloc_done && !alloc_full, "R1 alloc idle", {30'd0, alloc_done, alloc_full}, 0);
    do_lookup(32'h0001_0040, 3'd0, 1'b0, 7'd0, "R1 empty CAM forwards");
  endtask

  task automatic t_alloc_basic;
    do_alloc(20'h00010, 1, 0, 3'd0, "R7 first");
    do_alloc(20'h00020, 1, 0, 3'd1, "R7 second");
    do_alloc(20'h00030, 1, 0, 3'd2, "R7 third");
    @(negedge clk);
    check(!alloc_done, "R12 done is a pulse", 32'(alloc_done), 0);
  endtask

  task automatic t_index;
    do_lookup(32'h0002_02A4, 3'd0, 1, 7'd21, "R2 gran0");
    do_lookup(32'h0002_02A4, 3'd2, 1, 7'd17, "R3 gran2");
    do_lookup(32'h0002_0AA4, 3'd5, 1, 7'd16, "R3 gran5");
    do_lookup(32'h0002_0AA4, 3'd7, 1, 7'd16, "R3 gran7 as 5");
    do_lookup(32'h0002_0AA4, 3'd3, 1, 7'd18, "R3 gran3");
    do_lookup(32'h0003_0700, 3'd0, 1, 7'd46, "R2 slot2");
    do_lookup(32'h0002_0FFF, 3'd0, 1, 7'd31, "R4 clamp gran0");
    do_lookup(32'h0001_0800, 3'd0, 1, 7'd15, "R4 clamp at 16");
    do_lookup(32'h0002_0FFF, 3'd1, 1, 7'd31, "R4 edge gran1");
  endtask

  task automatic t_miss;
    do_lookup(32'h0009_9ABD, 3'd0, 0, 7'd0, "R5 miss");
    do_lookup(32'h0009_9AB2, 3'd4, 0, 7'd0, "R5 miss write");
  endtask

  task automatic t_backpressure;
    logic [6:0] held;
    res_ready = 1'b0;
    do_lookup(32'h0002_0180, 3'd0, 1, 7'd19, "R6 stalled hit");
    held = res_index;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(res_valid && res_index == held, "R6 held", 32'(res_index), 32'(held));
      check(!req_ready, "R6 req_ready low", 32'(req_ready), 0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    check(!res_valid, "R6 drop after accept", 32'(res_valid), 0);
    fwd_ready = 1'b0;
    do_lookup(32'h0007_7000, 3'd0, 0, 7'd0, "R6 stalled fwd");
    @(negedge clk);
    check(fwd_valid && fwd_addr == 32'h0007_7000, "R6 fwd held", fwd_addr, 32'h0007_7000);
    fwd_ready = 1'b1;
    @(negedge clk);
    check(!fwd_valid, "R6 fwd drop", 32'(fwd_valid), 0);
  endtask

  task automatic t_dup_full;
    do_alloc(20'h00020, 1, 0, 3'd1, "R10 duplicate");
    do_alloc(20'h00040, 1, 0, 3'd3, "R10 no extra entry");
    do_alloc(20'h00050, 1, 0, 3'd4, "R7 fill4");
    do_alloc(20'h00060, 1, 0, 3'd5, "R7 fill5");
    do_alloc(20'h00070, 1, 0, 3'd6, "R7 fill6");
    do_alloc(20'h00080, 1, 0, 3'd7, "R7 fill7");
    do_alloc(20'h00090, 0, 1, 3'd0, "R8 full");
    do_lookup(32'h0009_0000, 3'd0, 0, 7'd0, "R8 refused page forwards");
    do_lookup(32'h0008_0100, 3'd0, 1, 7'd114, "R2 slot7");
  endtask

  task automatic t_release;
    do_release(20'h00030);
    do_lookup(32'h0003_0700, 3'd0, 0, 7'd0, "R9 released forwards");
    do_alloc(20'h000A0, 1, 0, 3'd2, "R9 reuse lowest");
  endtask

  task automatic t_same_cycle;
    do_release(20'h00010);
    @(negedge clk);
    gran_sel = 3'd0; req_valid = 1'b1; req_addr = 32'h000B_0085;
    req_core = 4'h5; req_write = 1'b0;
    alloc_en = 1'b1; alloc_page = 20'h000B0;
    @(negedge clk);
    req_valid = 1'b0; alloc_en = 1'b0;
    check(fwd_valid && !res_valid, "R11 lookup sees old CAM", 32'(fwd_valid), 1);
    check(alloc_done && alloc_slot == 3'd0, "R11 alloc same cycle", 32'(alloc_slot), 0);
    do_lookup(32'h000B_0085, 3'd0, 1, 7'd1, "R11 later lookup hits");
    @(negedge clk);
    rel_en = 1'b1; rel_page = 20'h00020;
    alloc_en = 1'b1; alloc_page = 20'h000C0;
    @(negedge clk);
    rel_en = 1'b0; alloc_en = 1'b0;
    check(alloc_full && !alloc_done, "R11 freed slot not reused same cycle",
          32'(alloc_full), 1);
    do_alloc(20'h000C0, 1, 0, 3'd1, "R11 freed slot reused later");
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc_basic();
    t_index();
    t_miss();
    t_backpressure();
    t_dup_full();
    t_release();
    t_same_cycle();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule